// File: doc/BRIEF.md
# Prescaled One-Shot Countdown Timer

This block is a 32-bit one-shot down-counter driven from the core clock through a power-of-two prescaler. Software programs two things through a small synchronous register port. The first is a divide setting. The second is a start count. Writing the start count arms the timer and resets the prescaler. After `start_count × ratio` core clocks the block emits a one-cycle expiry pulse and returns to idle.

A read-only register returns how many timer counts are left. It gives the remaining core clocks divided by the divide ratio, rounded up. Because the prescaler is cleared on every start-count write, a countdown always begins on a prescaler boundary and never picks up a partial period.

Top module: `tmr_div_timer`

## Requirements
- R1: The divide ratio is 2^s, where s = ({div[3], div[1:0]} + 1) mod 8. For example, setting 0 divides by 2, 0x1 by 4, 0x8 by 32, 0xA by 128, and 0xB by 1.
- R2: A write to the divide register (select 0) keeps only bits 3, 1 and 0. Reading it back returns zero in every other bit.
- R3: A write to the start-count register (select 1) stores all 32 bits, and reading back returns them. A non-zero value raises `expire_o` exactly N × ratio clocks after the write edge, sampled in the cycle after that edge count.
- R4: `expire_o` is high for exactly one cycle per countdown. Afterwards the timer is idle.
- R5: A read of the remaining-count register (select 2) captured k clocks after the start write returns ceil((N×ratio − k)/ratio).
- R6: While the timer is idle, select 2 reads zero. This includes the time after expiry.
- R7: Writes to select 2 have no effect on the running countdown.
- R8: Writing a start count of zero stops any countdown. The timer stays idle and no expiry is raised.
- R9: Writing a new start count during a countdown restarts it with a cleared prescaler. Expiry then follows N_new × ratio clocks after that write.
- R10: After reset, every select reads zero, select 3 always reads zero, and `expire_o` is low. Read data appears on `rdata_o` in the cycle after the edge that samples `re_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe |
| sel_i | input | 2 | Register select: 0 divide, 1 start count, 2 remaining count, 3 unused |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| expire_o | output | 1 | One-cycle pulse when the countdown ends |

## Verification
The hardest point to reach is a remaining-count read that falls partway through a prescaler period. At that moment the rounded-up result differs from a plain truncation. To get there, the stimulus places the read strobe at a chosen clock offset after the start write, for every divide setting. The expected value is computed from the ceiling formula. A second delicate case is a start-count rewrite while a countdown is running. The stimulus issues it a few clocks into a long countdown and then measures expiry from the second write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned DIV_W  = 4;
  localparam int unsigned PRE_W  = 7;   // largest ratio is 128
  localparam logic [DIV_W-1:0] DIV_KEEP = 4'hB;

  typedef enum logic [1:0] {
    SEL_DIV  = 2'd0,
    SEL_INIT = 2'd1,
    SEL_CUR  = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  // shift = ({cfg[3], cfg[1:0]} + 1) mod 8
  function automatic logic [2:0] div_shift(input logic [DIV_W-1:0] cfg);
    return {cfg[3], cfg[1:0]} + 3'd1;
  endfunction
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [1:0]       sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] remain_i,
  output logic [DIV_W-1:0] div_cfg_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] init_q;
  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      init_q <= '0;
    end else if (we_i) begin
      if (sel_i == SEL_DIV)  div_q  <= wdata_i[DIV_W-1:0] & DIV_KEEP;
      if (sel_i == SEL_INIT) init_q <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (sel_e'(sel_i))
      SEL_DIV:  rd_mux[DIV_W-1:0] = div_q;
      SEL_INIT: rd_mux[CNT_W-1:0] = init_q;
      SEL_CUR:  rd_mux[CNT_W-1:0] = remain_i;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_mux;
  end

  assign div_cfg_o  = div_q;
  assign load_o     = we_i && (sel_i == SEL_INIT);
  assign load_val_o = wdata_i[CNT_W-1:0];
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_cfg_i,
  output logic             tick_o
);
  localparam int unsigned LIM_W = PRE_W + 1;

  logic [PRE_W-1:0] pre_q;
  logic [LIM_W-1:0] lim;

  assign lim    = (LIM_W'(1) << div_shift(div_cfg_i)) - LIM_W'(1);
  // >= so a smaller ratio picked mid-period still ends the period
  assign tick_o = en_i && (pre_q >= lim[PRE_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (clear_i) pre_q <= '0;
    else if (en_i)    pre_q <= tick_o ? '0 : pre_q + PRE_W'(1);
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      exp_q <= 1'b0;
    end else begin
      exp_q <= 1'b0;
      if (load_i) begin
        cnt_q <= load_val_i;
        run_q <= (load_val_i != '0);
      end else if (run_q && tick_i) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          run_q <= 1'b0;
          exp_q <= 1'b1;
        end
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign run_o    = run_q;
  assign expire_o = exp_q;
endmodule

// File: rtl/tmr_div_timer.sv
module tmr_div_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              expire_o
);
  logic [DIV_W-1:0] div_cfg;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             tick;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic [CNT_W-1:0] remain;

  // counts left equals ceil(clocks left / ratio) because the prescaler restarts on load
  assign remain = run_q ? cnt_q : '0;

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .we_i, .re_i, .sel_i, .wdata_i,
    .remain_i   (remain),
    .div_cfg_o  (div_cfg),
    .load_o     (load),
    .load_val_o (load_val),
    .rdata_o    (rdata_o)
  );

  tmr_prescaler u_pre (
    .clk_i, .rst_ni,
    .clear_i   (load),
    .en_i      (run_q),
    .div_cfg_i (div_cfg),
    .tick_o    (tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .load_i     (load),
    .load_val_i (load_val),
    .tick_i     (tick),
    .cnt_o      (cnt_q),
    .run_o      (run_q),
    .expire_o   (expire_o)
  );
endmodule

// File: rtl/tmr_div_timer_chk.sv
module tmr_div_timer_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic             re_i,
  input logic [1:0]       sel_i,
  input logic [31:0]      wdata_i,
  input logic [31:0]      rdata_o,
  input logic             expire_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic             run_q
);
  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o); // R4
  AST_EXPIRE_FROM_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> ($past(cnt_q) == CNT_W'(1))); // R3
  AST_ZERO_LOAD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == 2'd1 && wdata_i == '0) |=> (!run_q && !expire_o)); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> (cnt_q == '0)); // R6
  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !(we_i && sel_i == 2'd1)) |=>
      (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - CNT_W'(1))); // R5
  AST_DIV_RB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && sel_i == 2'd0) |=> (rdata_o[31:4] == '0 && rdata_o[2] == 1'b0)); // R2
endmodule

bind tmr_div_timer tmr_div_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .we_i, .re_i, .sel_i, .wdata_i, .rdata_o, .expire_o,
  .cnt_q (cnt_q),
  .run_q (run_q)
);

// File: tb/tmr_div_timer_test.sv
module tmr_div_timer_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0, re_i = 1'b0;
  logic [1:0]  sel_i = 2'd0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        expire_o;
  int n_chk = 0, n_fail = 0;

  always #4 clk_i = ~clk_i; // 125 MHz

  tmr_div_timer uut (.*);

  // {divide setting, start count, read offset}
  localparam int NV = 9;
  localparam logic [31:0] V_CFG  [NV] = '{32'hB, 32'h0, 32'h1, 32'h2, 32'h3, 32'h8, 32'h9, 32'hA, 32'hF4};
  localparam int          V_N    [NV] = '{5, 4, 3, 2, 2, 1, 1, 2, 3};
  localparam int          V_OFS  [NV] = '{2, 3, 5, 1, 16, 0, 10, 100, 1};

  function automatic int ratio_of(input logic [31:0] c);
    logic [2:0] s;
    s = {c[3], c[1:0]} + 3'd1;
    return 1 << s;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk_i); we_i = 1'b1; sel_i = s; wdata_i = d;
    @(negedge clk_i); we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] d);
    @(negedge clk_i); re_i = 1'b1; sel_i = s;
    @(negedge clk_i); re_i = 1'b0; d = rdata_o;
  endtask

  // negedges after return of wr until expiry; -1 if none within lim
  task automatic wait_expire(input int lim, output int k);
    int i;
    k = -1;
    for (i = 1; i <= lim; i++) begin
      @(negedge clk_i);
      if (expire_o) begin k = i; break; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int k;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R10 reset state
    check("R10 expire after reset", {31'd0, expire_o}, 32'd0);
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), d);
      check("R10 reset read", d, 32'd0);
    end

    // table walk: R1 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      int r, tot, m, first, pulses;
      r = ratio_of(V_CFG[v]); tot = V_N[v] * r; m = V_OFS[v];
      first = -1; pulses = 0;
      wr(2'd0, V_CFG[v]);
      wr(2'd1, 32'(V_N[v]));
      for (int kk = 0; kk <= tot + 1; kk++) begin
        if (kk > 0) @(negedge clk_i);
        if (kk == m + 1) begin
          re_i = 1'b0;
          check("R5 rounded remaining count", rdata_o, 32'((tot - m + r - 1) / r));
        end
        if (kk == m) begin re_i = 1'b1; sel_i = 2'd2; end
        if (kk > 0 && expire_o) begin
          pulses++;
          if (first < 0) first = kk;
        end
      end
      check("R1 R3 expiry clock count", 32'(first), 32'(tot));
      check("R4 single pulse", 32'(pulses), 32'd1);
      rd(2'd2, d);
      check("R6 idle after expiry", d, 32'd0);
    end

    // R2 divide mask
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d);
    check("R2 divide readback mask", d, 32'hB);

    // R3 full-width start count storage, then stop
    wr(2'd1, 32'hDEAD_BEEF);
    rd(2'd1, d);
    check("R3 start count readback", d, 32'hDEAD_BEEF);
    rd(2'd3, d);
    check("R10 unused select reads zero", d, 32'd0);

    // R8 zero start count stops countdown
    wr(2'd1, 32'd0);
    wait_expire(300, k);
    check("R8 no expiry after zero load", 32'(k), 32'hFFFF_FFFF);
    rd(2'd2, d);
    check("R8 idle read after zero load", d, 32'd0);

    // R7 write to remaining count ignored (ratio 1)
    wr(2'd1, 32'd40);
    wr(2'd2, 32'd5);
    rd(2'd2, d);
    check("R7 remaining count not overwritten", {31'd0, (d > 32'd30 && d <= 32'd40)}, 32'd1);
    wr(2'd1, 32'd0);

    // R9 restart mid-countdown, ratio 2
    wr(2'd0, 32'h0);
    wr(2'd1, 32'd10);
    repeat (5) @(negedge clk_i);
    wr(2'd1, 32'd3);
    wait_expire(100, k);
    check("R9 restart expiry timing", 32'(k), 32'd6);
    @(negedge clk_i);
    check("R4 pulse low after restart expiry", {31'd0, expire_o}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule